// File: doc/BRIEF.md
# Speculative Result Queue with In-Order Retirement

This block keeps the results of speculatively executed instructions in program order until they can safely update architectural state. The issue stage claims a slot when it dispatches an instruction and receives the slot number as that instruction's result tag. An execution unit later writes the result, plus flags for a raised exception or a mispredicted branch, into that slot. Consumers can read any occupied slot by tag to pick up a finished value before it has retired.

Retirement happens at the oldest slot only, one slot per cycle, and only once that slot holds a result. A retiring register operation drives a register-file write, and a retiring store drives a memory write. A retiring branch that was mispredicted discards every younger slot. A retiring instruction that raised an exception empties the whole queue and reports the slot number. A separate query tells the load path whether a load address matches the address of any store still waiting in the queue.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `alloc_tag` is 0, and `commit_valid`, `flush`, `exc_valid`, `reg_we`, `mem_we` and `ld_block` are all 0.
- R2: With DEPTH=7, allocation tags run 0,1,...,6 and then wrap to 0 in allocation order. `alloc_ready` is 0 while all seven slots are occupied or while `flush` is 1. An `alloc_valid` request made while `alloc_ready` is 0 is dropped and does not move the tag.
- R3: A write with `wr_valid` to an occupied slot stores the value and marks the slot finished. `lookup_ready`/`lookup_value` then return that slot's state and value. A write to a tag that has no occupied slot, such as a slot discarded by a flush, has no effect.
- R4: Retirement happens only at the oldest slot and only after its result has been written. At most one slot retires per cycle, in allocation order. `commit_valid` is 1 and `commit_tag` names the slot in the cycle before it is freed.
- R5: Type code 2'b00 (or 2'b11) is a register operation. When it retires without an exception, `reg_we` is 1, `commit_dest` is its register number and `commit_data` is its value.
- R6: Type code 2'b01 is a store. When it retires without an exception, `mem_we` is 1, `commit_dest` is its address, `commit_data` is the value to store, and `reg_we` is 0.
- R7: Type code 2'b10 is a branch. When it retires it writes nothing. If its result carried `wr_mispredict`, `flush` is 1 in that cycle and every younger slot is discarded. The next allocation then takes the tag just after the branch.
- R8: An exception flag written with a result causes nothing until that slot retires. In that cycle `exc_valid` and `flush` are 1, `exc_tag` names the slot, and no register or memory write is made. The queue is then emptied, and the next allocation takes the faulting slot's tag.
- R9: `ld_block` is 1 when an occupied store slot holds an address equal to `ld_addr`. Register operations with the same destination number do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Request a slot for a new instruction |
| alloc_type | input | 2 | Instruction type code |
| alloc_dest | input | AW | Register number or store address |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TW | Tag the next allocation receives |
| wr_valid | input | 1 | Result write strobe |
| wr_tag | input | TW | Slot the result belongs to |
| wr_value | input | DW | Result value (store data for stores) |
| wr_exc | input | 1 | Instruction raised an exception |
| wr_mispredict | input | 1 | Branch was mispredicted |
| lookup_tag | input | TW | Slot to read for operand forwarding |
| lookup_ready | output | 1 | Slot occupied and result present |
| lookup_value | output | DW | Result value of that slot |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_tag | output | TW | Tag of the retiring slot |
| reg_we | output | 1 | Register-file write enable |
| mem_we | output | 1 | Memory write enable |
| commit_dest | output | AW | Register number or memory address |
| commit_data | output | DW | Data to write |
| flush | output | 1 | Younger (or all) slots discarded |
| exc_valid | output | 1 | Exception taken at retirement |
| exc_tag | output | TW | Tag of the faulting slot |
| ld_addr | input | AW | Load address to check |
| ld_block | output | 1 | A pending store matches the load address |

## Verification
The hardest situations to reach are the ones where a slot that is already finished waits behind an older slot that is not, and then gets discarded. The bench creates them by writing results out of order, completing the younger slots and the mispredicted branch or faulting store before the oldest slot. It then completes the oldest slot so that the flush comes on the cycle after. Finally it writes a late result to a slot that was just discarded, and checks at the ports that nothing retires and the lookup reports the slot as empty.

// File: rtl/reorder_buffer.sv
`timescale 1ns/1ps
module reorder_buffer #(
  parameter int DEPTH = 7,
  parameter int DW    = 32,
  parameter int AW    = 16,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [1:0]    alloc_type,
  input  logic [AW-1:0] alloc_dest,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic          wr_valid,
  input  logic [TW-1:0] wr_tag,
  input  logic [DW-1:0] wr_value,
  input  logic          wr_exc,
  input  logic          wr_mispredict,
  input  logic [TW-1:0] lookup_tag,
  output logic          lookup_ready,
  output logic [DW-1:0] lookup_value,
  output logic          commit_valid,
  output logic [TW-1:0] commit_tag,
  output logic          reg_we,
  output logic          mem_we,
  output logic [AW-1:0] commit_dest,
  output logic [DW-1:0] commit_data,
  output logic          flush,
  output logic          exc_valid,
  output logic [TW-1:0] exc_tag,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_block
);
  localparam logic [1:0] K_STORE  = 2'b01;
  localparam logic [1:0] K_BRANCH = 2'b10;

  logic [1:0]    kind_q [DEPTH];
  logic [AW-1:0] dest_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] busy_q, done_q, fault_q, miss_q;
  logic [TW-1:0] head_q, tail_q;
  logic          hwrap_q, twrap_q;

  function automatic logic [TW:0] bump(input logic w, input logic [TW-1:0] p);
    if (p == TW'(DEPTH-1)) return {~w, {TW{1'b0}}};
    return {w, p + 1'b1};
  endfunction

  logic full, head_go, head_fault, head_store, head_branch, take, wr_hit;
  logic [DEPTH-1:0] st_match;

  assign full        = (head_q == tail_q) && (hwrap_q != twrap_q);
  assign head_go     = busy_q[head_q] && done_q[head_q];
  assign head_fault  = fault_q[head_q];
  assign head_store  = kind_q[head_q] == K_STORE;
  assign head_branch = kind_q[head_q] == K_BRANCH;

  assign commit_valid = head_go;
  assign commit_tag   = head_q;
  assign commit_dest  = dest_q[head_q];
  assign commit_data  = data_q[head_q];
  assign exc_valid    = head_go && head_fault;
  assign exc_tag      = head_q;
  assign flush        = head_go && (head_fault || (head_branch && miss_q[head_q]));
  assign reg_we       = head_go && !head_fault && !head_store && !head_branch;
  assign mem_we       = head_go && !head_fault && head_store;

  assign alloc_ready = !full && !flush;
  assign alloc_tag   = tail_q;
  assign take        = alloc_valid && alloc_ready;
  assign wr_hit      = wr_valid && (wr_tag < TW'(DEPTH)) && busy_q[wr_tag];

  assign lookup_ready = (lookup_tag < TW'(DEPTH)) && busy_q[lookup_tag] && done_q[lookup_tag];
  assign lookup_value = data_q[lookup_tag];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ld
    assign st_match[i] = busy_q[i] && (kind_q[i] == K_STORE) && (dest_q[i] == ld_addr);
  end
  assign ld_block = |st_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      done_q  <= '0;
      fault_q <= '0;
      miss_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      hwrap_q <= 1'b0;
      twrap_q <= 1'b0;
    end else begin
      if (wr_hit) begin
        done_q[wr_tag]  <= 1'b1;
        fault_q[wr_tag] <= wr_exc;
        miss_q[wr_tag]  <= wr_mispredict;
      end
      if (flush) begin
        busy_q <= '0;
        if (head_fault) begin
          tail_q  <= head_q;
          twrap_q <= hwrap_q;
        end else begin
          {hwrap_q, head_q} <= bump(hwrap_q, head_q);
          {twrap_q, tail_q} <= bump(hwrap_q, head_q);
        end
      end else begin
        if (head_go) begin
          busy_q[head_q] <= 1'b0;
          {hwrap_q, head_q} <= bump(hwrap_q, head_q);
        end
        if (take) begin
          busy_q[tail_q]  <= 1'b1;
          done_q[tail_q]  <= 1'b0;
          fault_q[tail_q] <= 1'b0;
          miss_q[tail_q]  <= 1'b0;
          {twrap_q, tail_q} <= bump(twrap_q, tail_q);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) data_q[wr_tag] <= wr_value;
    if (take) begin
      kind_q[tail_q] <= alloc_type;
      dest_q[tail_q] <= alloc_dest;
    end
  end
endmodule

module reorder_buffer_chk #(
  parameter int DEPTH = 7,
  localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_ready,
  input logic [TW-1:0] alloc_tag,
  input logic          commit_valid,
  input logic [TW-1:0] commit_tag,
  input logic          reg_we,
  input logic          mem_we,
  input logic          flush,
  input logic          exc_valid,
  input logic [TW-1:0] exc_tag
);
  logic [TW-1:0] seq_next;
  assign seq_next = (commit_tag == TW'(DEPTH-1)) ? '0 : commit_tag + 1'b1;

  // R4
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !flush) |=> (!commit_valid || commit_tag == $past(seq_next)));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush) |=> alloc_tag == $past(alloc_tag));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alloc_ready && !commit_valid));

  // R8
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (flush && !reg_we && !mem_we));

  // R8
  exc_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> alloc_tag == $past(exc_tag));
endmodule

bind reorder_buffer reorder_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
  .commit_valid(commit_valid), .commit_tag(commit_tag), .reg_we(reg_we),
  .mem_we(mem_we), .flush(flush), .exc_valid(exc_valid), .exc_tag(exc_tag)
);

// File: tb/reorder_buffer_tb.sv
`timescale 1ns/1ps
module reorder_buffer_tb;
  localparam logic [1:0] REG = 2'b00, ST = 2'b01, BR = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0; logic [1:0] alloc_type = 0; logic [15:0] alloc_dest = 0;
  logic wr_valid = 0; logic [2:0] wr_tag = 0; logic [31:0] wr_value = 0;
  logic wr_exc = 0, wr_mispredict = 0;
  logic [2:0] lookup_tag = 0; logic [15:0] ld_addr = 0;
  logic alloc_ready, lookup_ready, commit_valid, reg_we, mem_we, flush, exc_valid, ld_block;
  logic [2:0] alloc_tag, commit_tag, exc_tag;
  logic [31:0] lookup_value, commit_data;
  logic [15:0] commit_dest;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  reorder_buffer u_dut (.*);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic do_reset();
    alloc_valid = 0; wr_valid = 0; wr_exc = 0; wr_mispredict = 0;
    rst_n = 0; step(); rst_n = 1; step();
  endtask

  task automatic alloc(input logic [1:0] t, input logic [15:0] d, input int exp_tag);
    alloc_valid = 1; alloc_type = t; alloc_dest = d;
    check("R2", "alloc tag", alloc_tag, exp_tag);
    step(); alloc_valid = 0;
  endtask

  task automatic wr(input int tag, input logic [31:0] v, input logic e, input logic m);
    wr_valid = 1; wr_tag = 3'(tag); wr_value = v; wr_exc = e; wr_mispredict = m;
    step(); wr_valid = 0; wr_exc = 0; wr_mispredict = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "alloc_ready", alloc_ready, 1);
    check("R1", "alloc_tag", alloc_tag, 0);
    check("R1", "commit_valid", commit_valid, 0);
    check("R1", "flush/exc", {flush, exc_valid, reg_we, mem_we}, 0);
    ld_addr = 0; #0;
    check("R1", "ld_block", ld_block, 0);
  endtask

  task automatic t_in_order();
    do_reset();
    alloc(REG, 5, 0); alloc(REG, 6, 1); alloc(REG, 7, 2);
    wr(2, 32'hA2, 0, 0);
    check("R4", "no commit while head pending", commit_valid, 0);
    lookup_tag = 2; #1;
    check("R3", "lookup ready", lookup_ready, 1);
    check("R3", "lookup value", lookup_value, 32'hA2);
    lookup_tag = 1; #1;
    check("R3", "lookup not ready", lookup_ready, 0);
    wr(1, 32'hA1, 0, 0);
    check("R4", "still waiting on head", commit_valid, 0);
    wr(0, 32'hA0, 0, 0);
    check("R4", "commit tag0", {commit_valid, commit_tag}, {1'b1, 3'd0});
    check("R5", "reg write 0", {reg_we, mem_we, commit_dest}, {2'b10, 16'd5});
    check("R5", "data 0", commit_data, 32'hA0);
    step();
    check("R4", "commit tag1", {commit_valid, commit_tag}, {1'b1, 3'd1});
    check("R5", "dest 1", commit_dest, 6);
    step();
    check("R4", "commit tag2", {commit_valid, commit_tag}, {1'b1, 3'd2});
    check("R5", "data 2", {commit_dest, commit_data}, {16'd7, 32'hA2});
    step();
    check("R4", "drained", commit_valid, 0);
    check("R2", "next tag", alloc_tag, 3);
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < 7; i++) alloc(REG, 16'(i), i);
    check("R2", "full not ready", alloc_ready, 0);
    alloc_valid = 1; step(); alloc_valid = 0;
    check("R2", "dropped alloc keeps tag", alloc_tag, 0);
    wr(0, 32'h5, 0, 0);
    check("R4", "commit while full", commit_valid, 1);
    step();
    check("R2", "ready after retire", alloc_ready, 1);
    check("R2", "tag wrapped", alloc_tag, 0);
  endtask

  task automatic t_store();
    do_reset();
    alloc(ST, 16'h40, 0);
    alloc(REG, 16'h40, 1);
    ld_addr = 16'h40; #1;
    check("R9", "match blocks", ld_block, 1);
    ld_addr = 16'h44; #1;
    check("R9", "other addr", ld_block, 0);
    ld_addr = 16'h40;
    wr(0, 32'h1234, 0, 0);
    check("R6", "store commit", {mem_we, reg_we}, 2'b10);
    check("R6", "addr/data", {commit_dest, commit_data}, {16'h40, 32'h1234});
    step();
    check("R9", "reg op does not block", ld_block, 0);
  endtask

  task automatic t_branch_ok();
    do_reset();
    alloc(BR, 0, 0); alloc(REG, 4, 1);
    wr(1, 32'h44, 0, 0);
    wr(0, 32'h0, 0, 0);
    check("R7", "branch commits quietly", {commit_valid, flush, reg_we, mem_we}, 4'b1000);
    step();
    check("R7", "next retires", {commit_valid, reg_we, commit_dest}, {2'b11, 16'd4});
  endtask

  task automatic t_mispredict();
    do_reset();
    alloc(REG, 1, 0); alloc(BR, 0, 1); alloc(REG, 2, 2); alloc(REG, 3, 3);
    wr(2, 32'hC2, 0, 0); wr(3, 32'hC3, 0, 0); wr(1, 32'h0, 0, 1);
    check("R7", "no early flush", flush, 0);
    wr(0, 32'hC0, 0, 0);
    check("R7", "older commits first", {reg_we, flush}, 2'b10);
    step();
    check("R7", "flush on branch", {commit_valid, commit_tag, flush}, {1'b1, 3'd1, 1'b1});
    check("R7", "branch writes nothing", {reg_we, mem_we, alloc_ready}, 3'b000);
    step();
    check("R7", "tail after branch", alloc_tag, 2);
    check("R7", "no commit after flush", commit_valid, 0);
    lookup_tag = 2; #1;
    check("R7", "younger discarded", lookup_ready, 0);
    wr(3, 32'hDEAD, 0, 0);
    lookup_tag = 3; #1;
    check("R3", "late write ignored", {lookup_ready, commit_valid}, 2'b00);
    alloc(REG, 9, 2);
    lookup_tag = 2; #1;
    check("R3", "fresh slot not ready", lookup_ready, 0);
    wr(2, 32'h77, 0, 0);
    check("R5", "new path commits", {commit_valid, commit_tag, commit_dest, commit_data},
          {1'b1, 3'd2, 16'd9, 32'h77});
  endtask

  task automatic t_exception();
    do_reset();
    alloc(REG, 1, 0); alloc(ST, 16'h80, 1); alloc(REG, 3, 2);
    wr(1, 32'hE1, 1, 0);
    check("R8", "exception deferred", {exc_valid, flush}, 2'b00);
    wr(2, 32'hE2, 0, 0);
    wr(0, 32'hE0, 0, 0);
    check("R8", "older retires normally", {reg_we, exc_valid}, 2'b10);
    step();
    check("R8", "exception at commit", {exc_valid, exc_tag, flush}, {1'b1, 3'd1, 1'b1});
    check("R8", "faulting store not written", {mem_we, reg_we}, 2'b00);
    step();
    ld_addr = 16'h80; #1;
    check("R8", "tag rewound", alloc_tag, 1);
    check("R8", "emptied", {commit_valid, ld_block, alloc_ready}, 3'b001);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_in_order();
    t_full();
    t_store();
    t_branch_ok();
    t_mispredict();
    t_exception();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule